// File: doc/BRIEF.md
# Three-Channel Byte-Programmed Interval Timer

This block holds three independent 16-bit down-counters behind an 8-bit register port of four addresses. Addresses 0, 1 and 2 reach the data ports of counters 0, 1 and 2. Address 3 takes a control byte. Software first writes a control byte to one counter. That byte sets the counter's operating mode, binary or four-digit BCD counting, and the order in which bytes move through its data port. Software then writes the start value through the data port, one byte at a time. Each counter has a count-enable strobe (`cnt_tick`), a gate and an output. All three share the system clock, and a counter steps only on a clock edge where its strobe is high.

Three modes are built in. Terminal-count interrupt raises the output once the count runs out. Rate generator gives a one-interval low pulse every N intervals. Square wave toggles the output every N/2 intervals. The register port has no back-pressure. Every write and read strobe is taken in the cycle it is presented, so a source that feeds it as a stream sees ready held high at all times.

Top module: `itmr_top`

## Requirements
- R1: Control byte at address 3 uses these fields: bits 7:6 select the counter, bits 5:4 set the access order, bits 3:1 set the mode, bit 0 selects BCD (1) or binary (0). A select value of 3 writes no counter.
- R2: Access order 01 loads the written byte as the low byte with the high byte zero. Access order 10 loads it as the high byte with the low byte zero. Either way the new count takes effect on the write.
- R3: Access order 11 takes the low byte first and then the high byte. The count and the reload value change only on the high-byte write. A control write resets the byte order to low first.
- R4: A data-port read returns one byte of the live count, in the same byte order as writes. For order 11, each read strobe moves to the other byte.
- R5: While the gate is low, the counter ignores its strobe and holds its count.
- R6: Mode 0 (terminal-count interrupt, and every mode value other than 2 and 3) drives the output low on the control write and on the load. The output goes high on the Nth enabled strobe and stays high.
- R7: Mode 2 (rate generator) holds the output high after control and load. It drives the output low for exactly one strobe interval in every N intervals.
- R8: Mode 3 (square wave) starts with the output high after the load. It toggles the output every floor(N/2) enabled strobes.
- R9: In BCD each nibble wraps from 0 to 9, so the count steps down through 9999 to 0000.
- R10: A loaded value of zero counts as the maximum: 65536 strobes in binary, 10000 in BCD.
- R11: With access order 00, data writes are ignored and reads return the low byte of the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address (0-2 data, 3 control) |
| bus_wdata | input | 8 | Write byte |
| bus_wr | input | 1 | Write strobe, taken on this edge |
| bus_rd | input | 1 | Read strobe, advances the byte order on this edge |
| bus_rdata | output | 8 | Byte at the addressed data port (combinational) |
| cnt_tick | input | 3 | Per-counter count-enable strobe |
| cnt_gate | input | 3 | Per-counter gate, high enables counting |
| cnt_out | output | 3 | Per-counter output |

## Verification
The assertions assume four things about the inputs. Values written in BCD mode hold only digits 0 to 9. Rate-generator counts are at least 2. A write strobe and a read strobe never land on the same counter in the same cycle. The gate is held steady while its own checks run. The bench writes only valid BCD loads and rate values of 4 or more. It issues bus operations one at a time, each in its own task, and keeps all three gates high except in the gate-suspension scenario.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int CNT_W  = 16;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [1:0] {K_TC, K_RATE, K_SQUARE} kind_e;
  typedef enum logic [1:0] {ACC_NONE = 2'b00, ACC_LO = 2'b01, ACC_HI = 2'b10, ACC_LOHI = 2'b11} acc_e;

  function automatic kind_e kind_of(input logic [2:0] m);
    if (m == 3'd2) return K_RATE;
    if (m == 3'd3) return K_SQUARE;
    return K_TC;
  endfunction

  // One step down; zero wraps to the top value of the chosen radix.
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    if (!bcd) return v - 1'b1;
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (borrow) begin
        if (r[i*4 +: 4] == 4'd0) r[i*4 +: 4] = 4'd9;
        else begin
          r[i*4 +: 4] = r[i*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // Half of the load value in its own radix; zero stands for the maximum.
  function automatic logic [CNT_W-1:0] halve(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic [4:0] acc;
    logic rem;
    if (!bcd) return (v == '0) ? {1'b1, {(CNT_W-1){1'b0}}} : (v >> 1);
    if (v == '0) return {4'd5, {(CNT_W-4){1'b0}}};
    r = '0;
    rem = 1'b0;
    for (int i = DIGITS-1; i >= 0; i--) begin
      acc = (rem ? 5'd10 : 5'd0) + {1'b0, v[i*4 +: 4]};
      r[i*4 +: 4] = acc[4:1];
      rem = acc[0];
    end
    return r;
  endfunction
endpackage

// File: rtl/itmr_decode.sv
module itmr_decode #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        wdata,
  output logic [NUM_CH-1:0] ctrl_we,
  output logic [NUM_CH-1:0] data_we,
  output logic [NUM_CH-1:0] rd_adv
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  logic is_ctrl;
  assign is_ctrl = wr && (addr == CTRL_ADDR);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ctrl_we[c] = is_ctrl && (wdata[7:6] == 2'(c));
    assign data_we[c] = wr && (addr == ADDR_W'(c));
    assign rd_adv[c]  = rd && (addr == ADDR_W'(c));
  end

  // R1: at most one counter programmed per control write, none for select 3
  assert_one_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_we));
  assert_sel3_none_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && wdata[7:6] == 2'b11) |-> (ctrl_we == '0));
endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
  import itmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic       data_we,
  input  logic       rd_adv,
  input  logic [7:0] wdata,
  input  logic       tick,
  input  logic       gate,
  output logic       out,
  output logic [7:0] rbyte
);
  logic [2:0]       mode_q;
  acc_e             acc_q;
  logic             bcd_q, wptr_q, rptr_q, armed_q, out_q;
  logic [7:0]       lo_q;
  logic [CNT_W-1:0] reload_q, cnt_q;

  kind_e            kind, new_kind;
  logic             load, step;
  logic [CNT_W-1:0] new_n, nxt;

  assign kind     = kind_of(mode_q);
  assign new_kind = kind_of(wdata[3:1]);
  assign load     = data_we && ((acc_q == ACC_LO) || (acc_q == ACC_HI) ||
                                (acc_q == ACC_LOHI && wptr_q));
  assign step     = tick && gate && armed_q && !ctrl_we && !load;
  assign nxt      = step_down(cnt_q, bcd_q);

  always_comb begin
    case (acc_q)
      ACC_LO:  new_n = {8'h00, wdata};
      ACC_HI:  new_n = {wdata, 8'h00};
      default: new_n = {wdata, lo_q};
    endcase
  end

  always_comb begin
    if (acc_q == ACC_HI || (acc_q == ACC_LOHI && rptr_q)) rbyte = cnt_q[15:8];
    else rbyte = cnt_q[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      acc_q    <= ACC_LOHI;
      bcd_q    <= 1'b0;
      wptr_q   <= 1'b0;
      rptr_q   <= 1'b0;
      armed_q  <= 1'b0;
      out_q    <= 1'b0;
      lo_q     <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (ctrl_we) begin
      mode_q  <= wdata[3:1];
      acc_q   <= acc_e'(wdata[5:4]);
      bcd_q   <= wdata[0];
      wptr_q  <= 1'b0;
      rptr_q  <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= (new_kind != K_TC);
    end else begin
      if (data_we && acc_q == ACC_LOHI && !wptr_q) begin
        lo_q   <= wdata;
        wptr_q <= 1'b1;
      end
      if (load) begin
        reload_q <= new_n;
        wptr_q   <= 1'b0;
        armed_q  <= 1'b1;
        cnt_q    <= (kind == K_SQUARE) ? halve(new_n, bcd_q) : new_n;
        out_q    <= (kind != K_TC);
      end else if (step) begin
        case (kind)
          K_RATE: begin
            if (cnt_q == 16'd1) begin
              out_q <= 1'b0;
              cnt_q <= reload_q;
            end else begin
              out_q <= 1'b1;
              cnt_q <= nxt;
            end
          end
          K_SQUARE: begin
            if (cnt_q == 16'd1) begin
              out_q <= ~out_q;
              cnt_q <= halve(reload_q, bcd_q);
            end else cnt_q <= nxt;
          end
          default: begin
            cnt_q <= nxt;
            if (nxt == '0) out_q <= 1'b1;
          end
        endcase
      end
      if (rd_adv && acc_q == ACC_LOHI) rptr_q <= ~rptr_q;
    end
  end

  assign out = out_q;

  // R3: a low byte alone leaves the reload value untouched
  assert_lohi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !ctrl_we && acc_q == ACC_LOHI && !wptr_q) |=> $stable(reload_q));
  // R5: gate low freezes the count
  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !ctrl_we && !load) |=> $stable(cnt_q));
  // R6: terminal-count output, once high, stays high until reprogrammed
  assert_tc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_TC && out_q && !ctrl_we && !load) |=> out_q);
  // R7: rate-generator low pulse lasts one enabled interval
  assert_rate_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_RATE && !out_q && step && reload_q != 16'd1) |=> out_q);
  // R9: BCD count keeps every digit in 0..9
  assert_bcd_digits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd_q && armed_q) |-> (cnt_q[3:0] <= 4'd9 && cnt_q[7:4] <= 4'd9 &&
                            cnt_q[11:8] <= 4'd9 && cnt_q[15:12] <= 4'd9));
endmodule

// File: rtl/itmr_top.sv
module itmr_top #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic [NUM_CH-1:0] cnt_tick,
  input  logic [NUM_CH-1:0] cnt_gate,
  output logic [NUM_CH-1:0] cnt_out
);
  logic [NUM_CH-1:0] ctrl_we, data_we, rd_adv;
  logic [7:0]        rbyte [NUM_CH];

  itmr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .ctrl_we(ctrl_we), .data_we(data_we), .rd_adv(rd_adv)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    itmr_channel u_ch (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we[c]), .data_we(data_we[c]),
      .rd_adv(rd_adv[c]), .wdata(bus_wdata), .tick(cnt_tick[c]),
      .gate(cnt_gate[c]), .out(cnt_out[c]), .rbyte(rbyte[c])
    );
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int c = 0; c < NUM_CH; c++)
      if (bus_addr == ADDR_W'(c)) bus_rdata = rbyte[c];
  end
endmodule

// File: tb/itmr_top_tb_top.sv
`timescale 1ns/1ps
module itmr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [2:0] cnt_tick = '0, cnt_gate = 3'b111, cnt_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  itmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cnt_tick(cnt_tick), .cnt_gate(cnt_gate), .cnt_out(cnt_out)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int ch, input int n);
    @(negedge clk);
    cnt_tick[ch] = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick[ch] = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R6 reset outputs low", {13'd0, cnt_out}, 16'h0000);
    rd(2'd0, v);
    chk("R4 reset count", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_tc_lohi();
    logic [7:0] lo, hi;
    wr(2'd3, 8'h30);                 // ch0, low-then-high, mode 0, binary
    chk("R6 out low on control", {15'd0, cnt_out[0]}, 16'd0);
    wr(2'd0, 8'h05);
    ticks(0, 3);                      // not loaded yet, no effect
    rd(2'd0, lo); rd(2'd0, hi);
    chk("R3 count waits for high byte", {hi, lo}, 16'h0000);
    wr(2'd0, 8'h00);
    ticks(0, 4);
    chk("R6 out low before terminal", {15'd0, cnt_out[0]}, 16'd0);
    rd(2'd0, lo); rd(2'd0, hi);
    chk("R4 low-then-high read", {hi, lo}, 16'h0001);
    cnt_gate[0] = 1'b0;
    ticks(0, 5);
    rd(2'd0, lo); rd(2'd0, hi);
    chk("R5 gate low holds count", {hi, lo}, 16'h0001);
    cnt_gate[0] = 1'b1;
    ticks(0, 1);
    chk("R6 out high at terminal", {15'd0, cnt_out[0]}, 16'd1);
    ticks(0, 3);
    chk("R6 out stays high", {15'd0, cnt_out[0]}, 16'd1);
    wr(2'd3, 8'hC0);                 // select 3: must not touch ch0
    chk("R1 select 3 ignored", {15'd0, cnt_out[0]}, 16'd1);
  endtask

  task automatic t_rate();
    wr(2'd3, 8'h74);                 // ch1, lo/hi, mode 2
    chk("R7 out high after control", {15'd0, cnt_out[1]}, 16'd1);
    wr(2'd1, 8'h04); wr(2'd1, 8'h00);
    ticks(1, 3);
    chk("R7 high before pulse", {15'd0, cnt_out[1]}, 16'd1);
    ticks(1, 1);
    chk("R7 low pulse at N", {15'd0, cnt_out[1]}, 16'd0);
    ticks(1, 1);
    chk("R7 pulse one interval", {15'd0, cnt_out[1]}, 16'd1);
    ticks(1, 3);
    chk("R7 period N", {15'd0, cnt_out[1]}, 16'd0);
  endtask

  task automatic t_square();
    wr(2'd3, 8'hB6);                 // ch2, lo/hi, mode 3
    wr(2'd2, 8'h06); wr(2'd2, 8'h00);
    chk("R8 starts high", {15'd0, cnt_out[2]}, 16'd1);
    ticks(2, 2);
    chk("R8 high for N/2", {15'd0, cnt_out[2]}, 16'd1);
    ticks(2, 1);
    chk("R8 toggles low at N/2", {15'd0, cnt_out[2]}, 16'd0);
    ticks(2, 3);
    chk("R8 toggles high at N", {15'd0, cnt_out[2]}, 16'd1);
  endtask

  task automatic t_bcd();
    logic [7:0] lo, hi;
    wr(2'd3, 8'h11);                 // ch0, low only, mode 0, BCD
    wr(2'd0, 8'h10);
    ticks(0, 1);
    rd(2'd0, lo);
    chk("R9 BCD 10 to 09", {8'd0, lo}, 16'h0009);
    chk("R2 low-only load", {15'd0, cnt_out[0]}, 16'd0);
    ticks(0, 9);
    chk("R9 BCD terminal", {15'd0, cnt_out[0]}, 16'd1);
    wr(2'd3, 8'h31);                 // lo/hi, BCD, load 0000
    wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    ticks(0, 1);
    rd(2'd0, lo); rd(2'd0, hi);
    chk("R9 BCD 0000 wraps to 9999", {hi, lo}, 16'h9999);
    ticks(0, 9998);
    chk("R10 BCD not done at 9999", {15'd0, cnt_out[0]}, 16'd0);
    ticks(0, 1);
    chk("R10 BCD zero is 10000", {15'd0, cnt_out[0]}, 16'd1);
  endtask

  task automatic t_bin_max();
    wr(2'd3, 8'h70);                 // ch1, lo/hi, mode 0, binary, load 0
    wr(2'd1, 8'h00); wr(2'd1, 8'h00);
    ticks(1, 65535);
    chk("R10 binary not done at 65535", {15'd0, cnt_out[1]}, 16'd0);
    ticks(1, 1);
    chk("R10 binary zero is 65536", {15'd0, cnt_out[1]}, 16'd1);
  endtask

  task automatic t_hi_and_none();
    logic [7:0] v;
    wr(2'd3, 8'h20);                 // ch0, high only
    wr(2'd0, 8'h01);
    rd(2'd0, v);
    chk("R2 high-only load", {8'd0, v}, 16'h0001);
    ticks(0, 1);
    rd(2'd0, v);
    chk("R2 high byte after step", {8'd0, v}, 16'h0000);
    wr(2'd3, 8'h00);                 // access order 00
    wr(2'd0, 8'h55);
    rd(2'd0, v);
    chk("R11 write ignored, low byte read", {8'd0, v}, 16'h00FF);
    chk("R11 no load on ignored write", {15'd0, cnt_out[0]}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tc_lohi();
    t_rate();
    t_square();
    t_bcd();
    t_bin_max();
    t_hi_and_none();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule